// File: doc/BRIEF.md
# SPI Master Controller with Byte FIFOs

This block is a register-mapped master for a four-wire serial peripheral bus. Software writes bytes into a small transmit FIFO and reads the bytes that came back from a receive FIFO. The link moves 8 bits per word, most significant bit first. All four clock polarity/phase modes are available. The serial clock runs at a rate fixed when the block is built. The slave-select lines are active low and come from a register, one bit per slave.

The usual sequence is as follows. Set the transmit hold bit. Load the transmit FIFO. Select a slave. Then clear the hold bit. The shift engine drains the FIFO without gaps between bytes. For every byte it sends, it pushes one received byte into the receive FIFO. A one-cycle event marks the point where the last queued byte has finished and the transmit FIFO is empty. A fault input is monitored while the block is an enabled master, and a low level on it is recorded as a sticky status flag.

The shift engine has three states. `ENG_IDLE` holds SCK at its idle level. `ENG_HALF_A` is the first half of a bit: the line sits at its idle level when phase is 0 and at its active level when phase is 1. `ENG_HALF_B` is the second half of the bit. Each half lasts `CLK_DIV` clocks. The transitions are:
- `ENG_IDLE` to `ENG_HALF_A` when a byte is loaded.
- `ENG_HALF_A` to `ENG_HALF_B` at the end of the half. MISO is sampled here.
- `ENG_HALF_B` to `ENG_HALF_A` at the end of the half for the next bit, when the register shifts.
- `ENG_HALF_B` to `ENG_HALF_A` after the eighth bit when another byte may start, with the new byte loaded at once.
- `ENG_HALF_B` to `ENG_IDLE` after the eighth bit otherwise.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the control register reads 0x100 (hold set), the status register reads 0x05, the select register reads all ones, every `ss_n` line is high, SCK is low and `irq_tx_empty` is low.
- R2: The control register is at address 0. Its fields are: bit1 enable, bit2 master, bit3 polarity, bit4 phase, bit7 manual select, bit8 transmit hold. These fields read back as written, and every other bit reads 0.
- R3: No byte starts while the hold bit is 1, while enable is 0 or while master is 0, even if the transmit FIFO holds data. Once all three allow it, the FIFO drains in order with no idle state between bytes.
- R4: Each byte goes out MSB first over 8 SCK cycles. The slave sees each bit stable at the sampling edge: the rising edge when polarity equals phase, the falling edge otherwise. SCK sits at the polarity level whenever no byte is in flight.
- R5: Every byte sent pushes one received byte, MSB first, into the receive FIFO. Reading address 3 returns and pops the oldest byte. A read of an empty receive FIFO returns 0 and changes nothing.
- R6: The status register is at address 1, with bit0 receive empty, bit1 receive full, bit2 transmit empty, bit3 transmit full and bit4 mode fault. The full flags rise at `RX_DEPTH` and `TX_DEPTH` entries.
- R7: A write to address 2 pushes its low byte into the transmit FIFO. A write while the FIFO is full is dropped, so that byte is never sent.
- R8: Writing 1 to control bit5 empties the transmit FIFO, and writing 1 to bit6 empties the receive FIFO. Both bits read back 0.
- R9: The select register is at address 4 and is active low, with bit n for slave n. With manual select on, `ss_n` follows the register at all times. With manual select off, `ss_n` equals the register only while a byte is in flight, and is all ones otherwise.
- R10: `irq_tx_empty` is high for exactly one cycle when a byte finishes with the transmit FIFO empty. It stays low after bytes that are followed by another.
- R11: While enable and master are both 1, a low `fault_n` sets status bit4. The bit stays set until the status register is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data at address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of `reg_rd` |
| irq_tx_empty | output | 1 | One-cycle transmit-drained event |
| fault_n | input | 1 | Active-low mode-fault input |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The bench builds the block with `CLK_DIV`=2, both FIFO depths set to 4 and four slave selects. Short bytes (32 clocks) allow every polarity/phase mode to run multi-byte bursts within a small cycle budget. The shallow FIFOs let the bench reach both full flags and the dropped push with a handful of writes. MISO is wired to the inverse of MOSI, so each received byte is known and differs from the byte sent. A scoreboard rebuilds every transmitted byte from the bus at the mode's sampling edge and checks the selected slave line at each sampled bit.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int WORD_W = 8;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_STAT = 3'd1;
    localparam logic [2:0] ADDR_TXD  = 3'd2;
    localparam logic [2:0] ADDR_RXD  = 3'd3;
    localparam logic [2:0] ADDR_SSEL = 3'd4;

    localparam int CB_EN     = 1;
    localparam int CB_MASTER = 2;
    localparam int CB_CPOL   = 3;
    localparam int CB_CPHA   = 4;
    localparam int CB_TXRST  = 5;
    localparam int CB_RXRST  = 6;
    localparam int CB_MANUAL = 7;
    localparam int CB_HOLD   = 8;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_HALF_A = 2'd1,
        ENG_HALF_B = 2'd2
    } eng_state_t;

endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_byte,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              byte_end
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    eng_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] shreg_q;
    logic              samp_q;
    logic              half_end, last_bit;

    assign half_end = (cnt_q == CNT_LAST);
    assign last_bit = (bit_q == BIT_LAST);
    assign byte_end = (state_q == ENG_HALF_B) && half_end && last_bit;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:   if (go) state_d = ENG_HALF_A;
            ENG_HALF_A: if (half_end) state_d = ENG_HALF_B;
            ENG_HALF_B: begin
                if (half_end) begin
                    if (!last_bit) state_d = ENG_HALF_A;
                    else           state_d = go ? ENG_HALF_A : ENG_IDLE;
                end
            end
            default:    state_d = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            samp_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    cnt_q <= '0;
                    if (go) begin
                        shreg_q <= tx_byte;
                        bit_q   <= '0;
                    end
                end
                ENG_HALF_A: begin
                    cnt_q <= half_end ? '0 : cnt_q + 1'b1;
                    if (half_end) samp_q <= miso;
                end
                ENG_HALF_B: begin
                    cnt_q <= half_end ? '0 : cnt_q + 1'b1;
                    if (half_end) begin
                        if (last_bit) begin
                            if (go) begin
                                shreg_q <= tx_byte;
                                bit_q   <= '0;
                            end
                        end else begin
                            shreg_q <= {shreg_q[WORD_W-2:0], samp_q};
                            bit_q   <= bit_q + 1'b1;
                        end
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_pop  = go && ((state_q == ENG_IDLE) || byte_end);
        rx_push = byte_end;
        rx_byte = {shreg_q[WORD_W-2:0], samp_q};
        busy    = (state_q != ENG_IDLE);
        mosi    = shreg_q[WORD_W-1];
        unique case (state_q)
            ENG_IDLE:   sck = cpol;
            ENG_HALF_A: sck = cpol ^ cpha;
            ENG_HALF_B: sck = cpol ^ ~cpha;
            default:    sck = cpol;
        endcase
    end

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int NUM_SS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq_tx_empty,
    input  logic              fault_n,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    logic en_q, master_q, cpol_q, cpha_q, manual_q, inhibit_q, modef_q;
    logic [NUM_SS-1:0] ss_q;

    logic wr_ctrl, rd_stat;
    logic txf_flush, txf_push, txf_pop, txf_empty, txf_full;
    logic rxf_flush, rxf_push, rxf_pop, rxf_empty, rxf_full;
    logic [WORD_W-1:0] txf_dout, rxf_dout, rx_byte;
    logic eng_busy, byte_end, go;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;

    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    assign rd_stat   = reg_rd && (reg_addr == ADDR_STAT);
    assign txf_flush = wr_ctrl && reg_wdata[CB_TXRST];
    assign rxf_flush = wr_ctrl && reg_wdata[CB_RXRST];
    assign txf_push  = reg_wr && (reg_addr == ADDR_TXD);
    assign rxf_pop   = reg_rd && (reg_addr == ADDR_RXD);
    assign go        = en_q && master_q && !inhibit_q && !txf_empty;

    spi_host_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(txf_flush),
        .push(txf_push), .din(reg_wdata[WORD_W-1:0]),
        .pop(txf_pop), .dout(txf_dout), .empty(txf_empty), .full(txf_full)
    );

    spi_host_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(rxf_flush),
        .push(rxf_push), .din(rx_byte),
        .pop(rxf_pop), .dout(rxf_dout), .empty(rxf_empty), .full(rxf_full)
    );

    spi_host_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .cpol(cpol_q), .cpha(cpha_q),
        .tx_byte(txf_dout), .miso(miso), .tx_pop(txf_pop), .rx_push(rxf_push),
        .rx_byte(rx_byte), .sck(sck), .mosi(mosi), .busy(eng_busy),
        .byte_end(byte_end)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q         <= 1'b0;
            master_q     <= 1'b0;
            cpol_q       <= 1'b0;
            cpha_q       <= 1'b0;
            manual_q     <= 1'b0;
            inhibit_q    <= 1'b1;
            ss_q         <= '1;
            modef_q      <= 1'b0;
            irq_tx_empty <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q      <= reg_wdata[CB_EN];
                master_q  <= reg_wdata[CB_MASTER];
                cpol_q    <= reg_wdata[CB_CPOL];
                cpha_q    <= reg_wdata[CB_CPHA];
                manual_q  <= reg_wdata[CB_MANUAL];
                inhibit_q <= reg_wdata[CB_HOLD];
            end
            if (reg_wr && (reg_addr == ADDR_SSEL)) ss_q <= reg_wdata[NUM_SS-1:0];
            if (en_q && master_q && !fault_n) modef_q <= 1'b1;
            else if (rd_stat)                 modef_q <= 1'b0;
            irq_tx_empty <= byte_end && txf_empty;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CB_EN]     = en_q;
                reg_rdata[CB_MASTER] = master_q;
                reg_rdata[CB_CPOL]   = cpol_q;
                reg_rdata[CB_CPHA]   = cpha_q;
                reg_rdata[CB_MANUAL] = manual_q;
                reg_rdata[CB_HOLD]   = inhibit_q;
            end
            ADDR_STAT: reg_rdata[4:0] = {modef_q, txf_full, txf_empty, rxf_full, rxf_empty};
            ADDR_RXD:  reg_rdata[WORD_W-1:0] = rxf_empty ? '0 : rxf_dout;
            ADDR_SSEL: reg_rdata[NUM_SS-1:0] = ss_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign ss_n = (manual_q || eng_busy) ? ss_q : '1;

endmodule

// File: rtl/spi_host_checks.sv
module spi_host_checks (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic cpol,
    input logic busy,
    input logic inhibit,
    input logic irq,
    input logic tx_empty,
    input logic tx_full,
    input logic rx_empty,
    input logic rx_full,
    input logic en,
    input logic master,
    input logic fault_n,
    input logic modef
);
    assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol));

    assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !busy) |=> !busy);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_empty && tx_full) && !(rx_empty && rx_full));

    assert_fault_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !fault_n) |=> modef);

endmodule

bind spi_host_ctrl spi_host_checks u_checks (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cpol(cpol_q), .busy(eng_busy),
    .inhibit(inhibit_q), .irq(irq_tx_empty), .tx_empty(txf_empty),
    .tx_full(txf_full), .rx_empty(rxf_empty), .rx_full(rxf_full),
    .en(en_q), .master(master_q), .fault_n(fault_n), .modef(modef_q)
);

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
    localparam int CLK_DIV = 2;
    localparam int TXD = 4;
    localparam int RXD = 4;
    localparam int NSS = 4;

    localparam logic [15:0] C_EN = 16'h002, C_MST = 16'h004, C_POL = 16'h008,
                            C_PHA = 16'h010, C_TXR = 16'h020, C_RXR = 16'h040,
                            C_MAN = 16'h080, C_HLD = 16'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq_tx_empty, sck, mosi, miso;
    logic fault_n = 1'b1;
    logic [NSS-1:0] ss_n;

    int n_tests = 0, n_fail = 0;
    int mon_bytes = 0, irq_cnt = 0;
    logic m_cpol = 1'b0, m_cpha = 1'b0, m_pause = 1'b1;
    logic [NSS-1:0] exp_ss = '1;
    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] m_shift = '0;
    int m_bits = 0;

    always #4 clk = ~clk;
    assign miso = ~mosi;

    spi_host_ctrl #(.CLK_DIV(CLK_DIV), .TX_DEPTH(TXD), .RX_DEPTH(RXD), .NUM_SS(NSS)) u_spi_host_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_tx_empty(irq_tx_empty), .fault_n(fault_n), .sck(sck), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) if (irq_tx_empty) irq_cnt++;

    // monitor: rebuilds each byte at the sampling edge and scores it
    always @(posedge sck or negedge sck) begin
        if (m_pause) begin
            m_bits = 0;
        end else if (sck == ~(m_cpol ^ m_cpha)) begin
            chk(ss_n == exp_ss, "R9 select during bit", 16'(ss_n), 16'(exp_ss));
            m_shift = {m_shift[6:0], mosi};
            m_bits++;
            if (m_bits == 8) begin
                m_bits = 0;
                mon_bytes++;
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", 16'(m_shift), 16'h0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(m_shift == e, "R4 byte on bus", 16'(m_shift), 16'(e));
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string tag);
        logic [15:0] v;
        rd(a, v);
        chk(v == e, tag, v, e);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit expect_out);
        if (expect_out) begin
            exp_q.push_back(b);
            rx_q.push_back(~b);
        end
        wr(3'd2, {8'h00, b});
    endtask

    task automatic set_mode(input logic [15:0] c);
        m_pause = 1'b1;
        wr(3'd0, c);
        repeat (2) @(negedge clk);
        m_cpol = c[3];
        m_cpha = c[4];
        m_pause = 1'b0;
    endtask

    task automatic wait_bytes(input int target);
        int k;
        k = 0;
        while (mon_bytes < target && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(mon_bytes >= target, "R3 burst completes", 16'(mon_bytes), 16'(target));
        repeat (4 * CLK_DIV + 6) @(negedge clk);
    endtask

    task automatic drain_rx(input string tag);
        while (rx_q.size() > 0) begin
            logic [7:0] e;
            e = rx_q.pop_front();
            rd_chk(3'd3, {8'h00, e}, tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 16'h0, 16'h1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] base;
        int b0, i0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ss_n == '1, "R1 ss_n after reset", 16'(ss_n), 16'hF);
        chk(sck == 1'b0, "R1 sck after reset", 16'(sck), 16'h0);
        chk(irq_tx_empty == 1'b0, "R1 irq after reset", 16'(irq_tx_empty), 16'h0);
        rd_chk(3'd0, 16'h100, "R1 control after reset");
        rd_chk(3'd1, 16'h005, "R1 status after reset");
        rd_chk(3'd4, 16'h00F, "R1 select after reset");

        // R2 control readback, R8 reset bits self-clear
        base = C_EN | C_MST | C_MAN;
        set_mode(base | C_HLD);
        rd_chk(3'd0, base | C_HLD, "R2 control readback");
        wr(3'd0, base | C_HLD | C_TXR | C_RXR);
        rd_chk(3'd0, base | C_HLD, "R8 reset bits read zero");

        // R9 manual select follows register
        wr(3'd4, 16'h000E);
        exp_ss = 4'hE;
        @(negedge clk);
        chk(ss_n == 4'hE, "R9 manual select", 16'(ss_n), 16'hE);

        // R4/R5/R3/R10 all four modes
        for (int m = 0; m < 4; m++) begin
            logic [15:0] c;
            c = base | (m[0] ? C_POL : 16'h0) | (m[1] ? C_PHA : 16'h0);
            set_mode(c | C_HLD);
            chk(sck == m[0], "R4 idle level", 16'(sck), 16'(m[0]));
            b0 = mon_bytes;
            send_byte(8'hA5, 1'b1);
            send_byte(8'h3C ^ 8'(m), 1'b1);
            send_byte(8'h81 + 8'(m), 1'b1);
            repeat (20) @(negedge clk);
            chk(mon_bytes == b0, "R3 hold stops shifting", 16'(mon_bytes), 16'(b0));
            rd_chk(3'd1, 16'h001, "R3 tx held with data");
            i0 = irq_cnt;
            wr(3'd0, c);
            wait_bytes(b0 + 3);
            chk(irq_cnt == i0 + 1, "R10 one drain event", 16'(irq_cnt - i0), 16'h1);
            chk(sck == m[0], "R4 idle after burst", 16'(sck), 16'(m[0]));
            rd_chk(3'd1, 16'h004, "R6 status with rx data");
            drain_rx("R5 received byte");
            rd_chk(3'd3, 16'h000, "R5 empty rx reads zero");
            rd_chk(3'd1, 16'h005, "R5 status after drain");
        end

        // R7 push into full TX is dropped, R6 full flags
        set_mode(base | C_HLD);
        b0 = mon_bytes;
        send_byte(8'h11, 1'b1);
        send_byte(8'h22, 1'b1);
        send_byte(8'h44, 1'b1);
        send_byte(8'h88, 1'b1);
        send_byte(8'hF0, 1'b0);
        rd_chk(3'd1, 16'h009, "R6 tx full flag");
        wr(3'd0, base);
        wait_bytes(b0 + 4);
        chk(mon_bytes == b0 + 4, "R7 dropped byte not sent", 16'(mon_bytes - b0), 16'h4);
        rd_chk(3'd1, 16'h006, "R6 rx full flag");
        drain_rx("R7 rx order after full");
        rd_chk(3'd1, 16'h005, "R6 status empty again");

        // R8 RX flush
        wr(3'd0, base | C_HLD);
        b0 = mon_bytes;
        send_byte(8'h5A, 1'b1);
        send_byte(8'hC3, 1'b1);
        wr(3'd0, base);
        wait_bytes(b0 + 2);
        rd_chk(3'd1, 16'h004, "R8 rx holds bytes");
        rx_q.delete();
        wr(3'd0, base | C_RXR);
        rd_chk(3'd1, 16'h005, "R8 rx flushed");
        rd_chk(3'd3, 16'h000, "R8 rx read after flush");

        // R8 TX flush
        wr(3'd0, base | C_HLD);
        b0 = mon_bytes;
        send_byte(8'h99, 1'b0);
        send_byte(8'h66, 1'b0);
        wr(3'd0, base | C_HLD | C_TXR);
        rd_chk(3'd1, 16'h005, "R8 tx flushed");
        wr(3'd0, base);
        repeat (60) @(negedge clk);
        chk(mon_bytes == b0, "R8 flushed bytes not sent", 16'(mon_bytes), 16'(b0));

        // R3 enable off blocks shifting
        wr(3'd0, C_MST | C_MAN);
        b0 = mon_bytes;
        send_byte(8'h77, 1'b0);
        repeat (60) @(negedge clk);
        chk(mon_bytes == b0, "R3 disabled core idle", 16'(mon_bytes), 16'(b0));
        rd_chk(3'd1, 16'h001, "R3 byte still queued");
        wr(3'd0, C_MST | C_MAN | C_HLD | C_TXR);
        rd_chk(3'd1, 16'h005, "R8 flush after disable");

        // R9 automatic select
        wr(3'd0, C_EN | C_MST | C_HLD);
        wr(3'd4, 16'h000D);
        exp_ss = 4'hD;
        @(negedge clk);
        chk(ss_n == 4'hF, "R9 auto select idle", 16'(ss_n), 16'hF);
        b0 = mon_bytes;
        send_byte(8'hE7, 1'b1);
        send_byte(8'h18, 1'b1);
        wr(3'd0, C_EN | C_MST);
        repeat (5) @(negedge clk);
        chk(ss_n == 4'hD, "R9 auto select busy", 16'(ss_n), 16'hD);
        wait_bytes(b0 + 2);
        chk(ss_n == 4'hF, "R9 auto select released", 16'(ss_n), 16'hF);
        drain_rx("R5 received byte auto");

        // R11 mode fault
        @(negedge clk);
        fault_n = 1'b0;
        @(negedge clk);
        fault_n = 1'b1;
        rd_chk(3'd1, 16'h015, "R11 fault flagged");
        rd_chk(3'd1, 16'h005, "R11 fault cleared by read");

        chk(exp_q.size() == 0, "R4 all queued bytes seen", 16'(exp_q.size()), 16'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule